// File: doc/BRIEF.md
# PHY Control-Register Handshake Master

This block sits between a simple command interface and the internal control-register port of a serial PHY. Each command is one of three kinds: load a register address, write a data word, or read a data word. The block turns each command into a series of strobe pulses. Every pulse follows a four-phase exchange with the PHY's single acknowledge line. It returns a one-cycle completion pulse with an error flag, and for reads the captured 16-bit value.

The PHY acknowledges each strobe edge at its own pace. The block therefore samples the acknowledge line at most a fixed number of times per edge, and waits a programmable number of idle cycles between samples. If the expected level never arrives, the command ends with an error. Writing the reset bit of the PHY's clock/reset register puts the PHY into reset, so it cannot acknowledge that write. The block finishes such a write without waiting and leaves the write strobe raised until the next command.

Top module: `phyreg_hs_master`

## Requirements
- R1: While `rst` is high and after it is released, `busy`, `done`, `error`, every strobe and `phy_bus_out` are all low until a command is accepted.
- R2: An address command (op code 0) drives the word on `phy_bus_out` at least one cycle before `phy_addr_stb` rises. It completes with `error` low, and a later write or read then targets that address.
- R3: Each strobe stays high until acknowledge is sampled high, then stays low until acknowledge is sampled low. At most one of the four strobes is high at any time.
- R4: Acknowledge is sampled first in the cycle after a strobe rises, then every `wait_cycles`+1 cycles, and at most MAX_POLLS (10) times per edge. If acknowledge stays low after a rise, `done` is high with `error` high in the cycle after clock edge 2+(MAX_POLLS-1)*(`wait_cycles`+1), counting the accepting edge as edge 0. In that cycle all strobes are low.
- R5: If acknowledge never falls after a successful rise, the command also ends with `error` high, one edge later than the R4 case.
- R6: A write command (op code 1) drives the word, completes a full handshake on `phy_data_stb`, then a full handshake on `phy_wr_stb`. It ends with `error` low and `phy_wr_stb` low.
- R7: If the last captured address is RST_REG_ADDR (0x7F3F) and bit 0 of the write word is 1, then `phy_wr_stb` rises in the same cycle that `done` pulses with `error` low, after the data handshake. `phy_wr_stb` stays high, with `busy` low, until the next command is accepted.
- R8: A write with bit 0 set to any other address takes the normal path of R6.
- R9: A read command (op code 2) raises `phy_rd_stb` and captures `phy_bus_in` when acknowledge is sampled high. It completes the falling handshake and presents the value on `rd_data` from the `done` cycle until the next read.
- R10: While `busy` is high, `cmd_valid` is ignored and no command is queued. Op code 3 is never accepted. `done` lasts exactly one cycle, `busy` is low while `done` is high, and `error` is high only together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command request, taken only while idle |
| cmd_op | input | 2 | 0 address, 1 write, 2 read, 3 no operation |
| cmd_word | input | DATA_W | Address or write data |
| wait_cycles | input | WAIT_W | Idle cycles between acknowledge samples |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Timeout flag, valid with `done` |
| rd_data | output | DATA_W | Last word read |
| phy_bus_out | output | DATA_W | Address/data word toward the PHY |
| phy_addr_stb | output | 1 | Capture-address strobe |
| phy_data_stb | output | 1 | Capture-data strobe |
| phy_wr_stb | output | 1 | Write strobe |
| phy_rd_stb | output | 1 | Read strobe |
| phy_ack | input | 1 | PHY acknowledge |
| phy_bus_in | input | DATA_W | Read data from the PHY |

## Verification
The bench targets the exact cycle of a timeout at two poll spacings. A wrong poll limit or interval would move `done`, and a design that timed out without lowering its strobe would be visible in that cycle. It drives the reset-register write and checks that `done` comes with the write strobe still high, while a bit-0 write to another address must finish with the strobe low. Commands injected while busy, and the no-operation code, must leave no trace in read-back data or in extra completions. Random writes and reads under varying acknowledge delays catch lost or wrongly latched data.

// File: rtl/crhs_pkg.sv
package crhs_pkg;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_NOP   = 2'd3
    } crhs_op_e;

    // strobe selector; value k+1 drives strobe line k
    typedef enum logic [2:0] {
        STB_NONE = 3'd0,
        STB_ADDR = 3'd1,
        STB_DATA = 3'd2,
        STB_WR   = 3'd3,
        STB_RD   = 3'd4
    } crhs_stb_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RISE,
        ST_FALL
    } crhs_state_e;

    localparam int NUM_STB = 4;

endpackage

// File: rtl/crhs_poll_timer.sv
module crhs_poll_timer #(
    parameter int WAIT_W    = 8,
    parameter int MAX_POLLS = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WAIT_W-1:0] wait_cycles,
    input  logic              arm,
    input  logic              miss,
    output logic              tick,
    output logic              last_poll
);
    localparam int POLL_W = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;

    typedef struct packed {
        logic [WAIT_W-1:0] cnt;
        logic [POLL_W-1:0] polls;
    } tmr_t;

    tmr_t d, q;

    always_comb begin
        d = q;
        if (arm) begin
            d.cnt   = '0;
            d.polls = '0;
        end else if (miss) begin
            d.cnt   = wait_cycles;
            d.polls = q.polls + POLL_W'(1);
        end else if (q.cnt != '0) begin
            d.cnt = q.cnt - WAIT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    assign tick      = (q.cnt == '0);
    assign last_poll = (q.polls == POLL_W'(MAX_POLLS - 1));

    p_poll_bound_r4: assert property (@(posedge clk) disable iff (rst)
        q.polls <= POLL_W'(MAX_POLLS - 1));

    p_miss_on_tick_r4: assert property (@(posedge clk) disable iff (rst)
        miss |-> (q.cnt == '0));

endmodule

// File: rtl/crhs_seq.sv
module crhs_seq
    import crhs_pkg::*;
#(
    parameter int              DATA_W       = 16,
    parameter logic [DATA_W-1:0] RST_REG_ADDR = 16'h7F3F,
    parameter int              RST_BIT      = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_word,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_bus_in,
    input  logic              tick,
    input  logic              last_poll,
    output logic              arm,
    output logic              miss,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] bus_out,
    output logic              raise,
    output crhs_stb_e         cur,
    output logic              wr_hold
);
    typedef struct packed {
        crhs_state_e       state;
        crhs_op_e          op;
        crhs_stb_e         cur;
        logic              raise;
        logic              wr_hold;
        logic              busy;
        logic              done;
        logic              err;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] last_addr;
        logic [DATA_W-1:0] rd;
    } seq_t;

    seq_t d, q;
    logic reset_write;

    always_comb begin
        d       = q;
        arm     = 1'b0;
        miss    = 1'b0;
        d.done  = 1'b0;
        d.err   = 1'b0;
        reset_write = (q.last_addr == RST_REG_ADDR) && q.data[RST_BIT];

        case (q.state)
            ST_IDLE: begin
                if (cmd_valid && (crhs_op_e'(cmd_op) != OP_NOP)) begin
                    d.state   = ST_SETUP;
                    d.busy    = 1'b1;
                    d.op      = crhs_op_e'(cmd_op);
                    d.wr_hold = 1'b0;
                    if (crhs_op_e'(cmd_op) != OP_READ) d.data = cmd_word;
                end
            end
            ST_SETUP: begin
                d.state = ST_RISE;
                d.raise = 1'b1;
                arm     = 1'b1;
                case (q.op)
                    OP_ADDR:  d.cur = STB_ADDR;
                    OP_WRITE: d.cur = STB_DATA;
                    default:  d.cur = STB_RD;
                endcase
            end
            ST_RISE: begin
                if (tick) begin
                    if (phy_ack) begin
                        if (q.cur == STB_RD) d.rd = phy_bus_in;
                        d.raise = 1'b0;
                        d.state = ST_FALL;
                        arm     = 1'b1;
                    end else if (last_poll) begin
                        d.state = ST_IDLE;
                        d.busy  = 1'b0;
                        d.done  = 1'b1;
                        d.err   = 1'b1;
                        d.raise = 1'b0;
                        d.cur   = STB_NONE;
                    end else begin
                        miss = 1'b1;
                    end
                end
            end
            ST_FALL: begin
                if (tick) begin
                    if (!phy_ack) begin
                        if ((q.cur == STB_DATA) && !reset_write) begin
                            d.cur   = STB_WR;
                            d.raise = 1'b1;
                            d.state = ST_RISE;
                            arm     = 1'b1;
                        end else begin
                            if (q.cur == STB_ADDR) d.last_addr = q.data;
                            if (q.cur == STB_DATA) d.wr_hold   = 1'b1;
                            d.state = ST_IDLE;
                            d.busy  = 1'b0;
                            d.done  = 1'b1;
                            d.cur   = STB_NONE;
                        end
                    end else if (last_poll) begin
                        d.state = ST_IDLE;
                        d.busy  = 1'b0;
                        d.done  = 1'b1;
                        d.err   = 1'b1;
                        d.cur   = STB_NONE;
                    end else begin
                        miss = 1'b1;
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.op    <= OP_ADDR;
            q.cur   <= STB_NONE;
        end else begin
            q <= d;
        end
    end

    assign busy    = q.busy;
    assign done    = q.done;
    assign error   = q.err;
    assign rd_data = q.rd;
    assign bus_out = q.data;
    assign raise   = q.raise;
    assign cur     = q.cur;
    assign wr_hold = q.wr_hold;

    p_err_with_done_r10: assert property (@(posedge clk) disable iff (rst)
        q.err |-> q.done);

    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        q.done |=> !q.done);

    p_rd_stable_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(q.rd) |-> q.busy);

    p_hold_idle_r7: assert property (@(posedge clk) disable iff (rst)
        q.wr_hold |-> !q.busy);

endmodule

// File: rtl/crhs_strobe_dec.sv
module crhs_strobe_dec
    import crhs_pkg::*;
(
    input  logic               raise,
    input  crhs_stb_e          cur,
    input  logic               wr_hold,
    output logic [NUM_STB-1:0] lines
);
    for (genvar k = 0; k < NUM_STB; k++) begin : g_line
        if (k == int'(STB_WR) - 1) begin : g_wr
            assign lines[k] = (raise && (cur == crhs_stb_e'(k + 1))) || wr_hold;
        end else begin : g_plain
            assign lines[k] = raise && (cur == crhs_stb_e'(k + 1));
        end
    end
endmodule

// File: rtl/phyreg_hs_master.sv
module phyreg_hs_master
    import crhs_pkg::*;
#(
    parameter int                DATA_W       = 16,
    parameter int                WAIT_W       = 8,
    parameter int                MAX_POLLS    = 10,
    parameter logic [DATA_W-1:0] RST_REG_ADDR = 16'h7F3F,
    parameter int                RST_BIT      = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_word,
    input  logic [WAIT_W-1:0] wait_cycles,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] phy_bus_out,
    output logic              phy_addr_stb,
    output logic              phy_data_stb,
    output logic              phy_wr_stb,
    output logic              phy_rd_stb,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_bus_in
);
    logic               tick, last_poll, arm, miss, raise, wr_hold;
    crhs_stb_e          cur;
    logic [NUM_STB-1:0] lines;

    crhs_poll_timer #(
        .WAIT_W    (WAIT_W),
        .MAX_POLLS (MAX_POLLS)
    ) i_timer (
        .clk         (clk),
        .rst         (rst),
        .wait_cycles (wait_cycles),
        .arm         (arm),
        .miss        (miss),
        .tick        (tick),
        .last_poll   (last_poll)
    );

    crhs_seq #(
        .DATA_W       (DATA_W),
        .RST_REG_ADDR (RST_REG_ADDR),
        .RST_BIT      (RST_BIT)
    ) i_seq (
        .clk        (clk),
        .rst        (rst),
        .cmd_valid  (cmd_valid),
        .cmd_op     (cmd_op),
        .cmd_word   (cmd_word),
        .phy_ack    (phy_ack),
        .phy_bus_in (phy_bus_in),
        .tick       (tick),
        .last_poll  (last_poll),
        .arm        (arm),
        .miss       (miss),
        .busy       (busy),
        .done       (done),
        .error      (error),
        .rd_data    (rd_data),
        .bus_out    (phy_bus_out),
        .raise      (raise),
        .cur        (cur),
        .wr_hold    (wr_hold)
    );

    crhs_strobe_dec i_dec (
        .raise   (raise),
        .cur     (cur),
        .wr_hold (wr_hold),
        .lines   (lines)
    );

    assign phy_addr_stb = lines[0];
    assign phy_data_stb = lines[1];
    assign phy_wr_stb   = lines[2];
    assign phy_rd_stb   = lines[3];

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !(phy_addr_stb || phy_data_stb || phy_rd_stb));

    p_setup_data_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_addr_stb) |-> $stable(phy_bus_out));

    p_one_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0({phy_addr_stb, phy_data_stb, phy_wr_stb, phy_rd_stb}));

    p_addr_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(phy_addr_stb) |-> ($past(phy_ack) || (done && error)));

    p_data_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(phy_data_stb) |-> ($past(phy_ack) || (done && error)));

    p_read_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(phy_rd_stb) |-> ($past(phy_ack) || (done && error)));

endmodule

// File: tb/test_phyreg_hs_master.sv
module test_phyreg_hs_master;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [1:0]  cmd_op;
    logic [15:0] cmd_word;
    logic [7:0]  wait_cycles;
    logic        busy, done, error;
    logic [15:0] rd_data, bus_out, bus_in;
    logic        addr_stb, data_stb, wr_stb, rd_stb;
    logic        ack;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    phyreg_hs_master i_phyreg_hs_master (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_word(cmd_word), .wait_cycles(wait_cycles), .busy(busy),
        .done(done), .error(error), .rd_data(rd_data),
        .phy_bus_out(bus_out), .phy_addr_stb(addr_stb),
        .phy_data_stb(data_stb), .phy_wr_stb(wr_stb), .phy_rd_stb(rd_stb),
        .phy_ack(ack), .phy_bus_in(bus_in)
    );

    // ---------------- PHY model (bench side) ----------------
    int          ack_mode = 0;  // 0 follow, 1 stuck low, 2 stuck high
    int          ack_lat  = 0;
    int          lat_cnt  = 0;
    logic [15:0] m_addr = '0, m_latch = '0, p_bus = '0;
    logic [15:0] m_regs [16];
    logic [15:0] ref_regs [16];
    logic        p_a = 0, p_d = 0, p_w = 0;
    int          bad_setup = 0;
    logic        any_stb;

    assign any_stb = addr_stb | data_stb | wr_stb | rd_stb;
    assign bus_in  = m_regs[m_addr[3:0]];

    initial begin
        ack = 1'b0;
        for (int i = 0; i < 16; i++) begin
            m_regs[i]   = 16'(i * 16'h0707 + 16'h0101);
            ref_regs[i] = 16'(i * 16'h0707 + 16'h0101);
        end
    end

    always @(posedge clk) begin
        p_a   <= addr_stb;
        p_d   <= data_stb;
        p_w   <= wr_stb;
        p_bus <= bus_out;
        if (addr_stb && !p_a) begin
            m_addr <= bus_out;
            if (bus_out != p_bus) bad_setup <= bad_setup + 1;
        end
        if (data_stb && !p_d) m_latch <= bus_out;
        if (wr_stb && !p_w && m_addr != 16'h7F3F) m_regs[m_addr[3:0]] <= m_latch;
        if (ack_mode == 1)      ack <= 1'b0;
        else if (ack_mode == 2) ack <= 1'b1;
        else if (any_stb != ack) begin
            if (lat_cnt >= ack_lat) begin
                ack     <= any_stb;
                lat_cnt <= 0;
            end else begin
                lat_cnt <= lat_cnt + 1;
            end
        end else begin
            lat_cnt <= 0;
        end
    end

    // ---------------- helpers ----------------
    function automatic int timeout_edges(int w, bit on_fall);
        return 2 + 9 * (w + 1) + (on_fall ? 1 : 0);
    endfunction

    task automatic chk(string req, string what, longint act, longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    logic        r_err, r_wr, r_any, r_done2;
    logic [15:0] r_rd;
    int          r_cyc;

    task automatic run_cmd(input logic [1:0] op, input logic [15:0] word, input bit inject);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_word = word;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        r_cyc = 0;
        for (int k = 0; k < 5000; k++) begin
            @(posedge clk);
            r_cyc++;
            @(negedge clk);
            if (done) break;
            if (inject && r_cyc == 2) begin
                cmd_valid = 1'b1; cmd_op = 2'd1; cmd_word = 16'hBEEF;
            end else begin
                cmd_valid = 1'b0;
            end
        end
        cmd_valid = 1'b0;
        r_err = error; r_rd = rd_data; r_wr = wr_stb;
        r_any = addr_stb | data_stb | wr_stb | rd_stb;
        @(negedge clk);
        r_done2 = done;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_word = '0; wait_cycles = 8'd0;
        repeat (3) @(negedge clk);
        chk("R1", "busy in reset", busy, 0);
        chk("R1", "strobes in reset", any_stb, 0);
        chk("R1", "bus in reset", bus_out, 0);
        rst = 1'b0;
        idle(2);
        chk("R1", "done/error after reset", {done, error}, 0);
        chk("R1", "strobes after reset", any_stb, 0);

        // R2, R6, R9 basic
        run_cmd(2'd0, 16'h0004, 0);
        chk("R2", "addr error", r_err, 0);
        chk("R10", "done one cycle", r_done2, 0);
        chk("R10", "busy low with done", busy, 0);
        run_cmd(2'd1, 16'hA55A, 0);
        ref_regs[4] = 16'hA55A;
        chk("R6", "write error", r_err, 0);
        chk("R6", "write strobe low at done", r_wr, 0);
        run_cmd(2'd2, 16'h0000, 0);
        chk("R9", "read error", r_err, 0);
        chk("R9", "read data", r_rd, ref_regs[4]);
        idle(3);
        chk("R9", "read data held", rd_data, ref_regs[4]);
        wait_cycles = 8'd3; ack_lat = 4;
        run_cmd(2'd0, 16'h0009, 0);
        run_cmd(2'd2, 16'h0000, 0);
        chk("R9", "read data slow ack", r_rd, ref_regs[9]);
        chk("R3", "no strobe after read", r_any, 0);

        // R4 rising timeout, two spacings
        ack_lat = 0; ack_mode = 1; wait_cycles = 8'd2;
        run_cmd(2'd0, 16'h0001, 0);
        chk("R4", "timeout error", r_err, 1);
        chk("R4", "timeout cycle w=2", r_cyc, timeout_edges(2, 0));
        chk("R4", "strobes low at timeout", r_any, 0);
        wait_cycles = 8'd0;
        run_cmd(2'd2, 16'h0000, 0);
        chk("R4", "timeout cycle w=0", r_cyc, timeout_edges(0, 0));
        // R5 falling timeout
        ack_mode = 2; wait_cycles = 8'd2;
        run_cmd(2'd0, 16'h0001, 0);
        chk("R5", "fall timeout error", r_err, 1);
        chk("R5", "fall timeout cycle", r_cyc, timeout_edges(2, 1));
        ack_mode = 0; idle(4);

        // R7 reset write
        wait_cycles = 8'd1; ack_lat = 0;
        run_cmd(2'd0, 16'h7F3F, 0);
        chk("R2", "reset reg addr", r_err, 0);
        run_cmd(2'd1, 16'h0001, 0);
        chk("R7", "reset write error", r_err, 0);
        chk("R7", "write high at done", r_wr, 1);
        begin
            int held = 0;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (wr_stb && !busy) held++;
            end
            chk("R7", "write held idle", held, 10);
        end
        run_cmd(2'd0, 16'h0002, 0);
        chk("R7", "write dropped by next cmd", r_wr, 0);
        chk("R7", "next cmd ok", r_err, 0);

        // R8 bit0 write to other address
        run_cmd(2'd0, 16'h0003, 0);
        run_cmd(2'd1, 16'h0001, 0);
        ref_regs[3] = 16'h0001;
        chk("R8", "normal write strobe low", r_wr, 0);
        run_cmd(2'd2, 16'h0000, 0);
        chk("R8", "bit0 write landed", r_rd, 16'h0001);

        // R10 ignore while busy, NOP
        wait_cycles = 8'd2; ack_lat = 2;
        run_cmd(2'd0, 16'h0005, 1);
        chk("R10", "addr with inject", r_err, 0);
        begin
            int extra = 0;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (busy || done) extra++;
            end
            chk("R10", "no queued command", extra, 0);
        end
        run_cmd(2'd2, 16'h0000, 1);
        chk("R10", "reg5 untouched", r_rd, ref_regs[5]);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'd3; cmd_word = 16'h1234;
        @(negedge clk);
        cmd_valid = 1'b0;
        begin
            int act = 0;
            for (int k = 0; k < 6; k++) begin
                @(negedge clk);
                if (busy || done || any_stb) act++;
            end
            chk("R10", "nop ignored", act, 0);
        end

        // random traffic
        for (int it = 0; it < 40; it++) begin
            logic [3:0]  a;
            logic [15:0] v;
            a = 4'($urandom_range(0, 15));
            v = 16'($urandom);
            wait_cycles = 8'($urandom_range(0, 3));
            ack_lat = $urandom_range(0, 4);
            run_cmd(2'd0, {12'h000, a}, 0);
            chk("R2", "rand addr", r_err, 0);
            if ($urandom_range(0, 1) == 1) begin
                run_cmd(2'd1, v, 0);
                ref_regs[a] = v;
                chk("R6", "rand write", {r_err, r_wr}, 0);
            end else begin
                run_cmd(2'd2, 16'h0000, 0);
                chk("R9", "rand read", r_rd, ref_regs[a]);
            end
        end
        chk("R2", "data set up before address strobe", bad_setup, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule